// File: doc/BRIEF.md
# Multi-Mode Gray-Coded Symbol Mapper

This block turns a serial stream of data bits into signed in-phase and quadrature amplitude codes. It serves four modulations from one datapath: binary phase keying (one bit per symbol), quadrature phase keying (two bits), π/4-shifted differential quadrature phase keying (two bits), and 16-point quadrature amplitude modulation (four bits). Bits arrive one per cycle, qualified by a valid strobe. When the last bit of a group arrives, the block emits one symbol with a one-cycle strobe.

Every frame holds 136 symbols, whatever the modulation. The block counts symbols and marks the first and last symbol of each frame. It also marks the symbols that carry the 32-bit synchronisation preamble that opens each frame. The modulation is sampled only on the first bit of a frame, so a change requested in mid-frame waits for the next frame.

In the differential mode the block keeps the carrier phase as an index in steps of π/4. Every symbol advances that index by an odd number of steps. The index restarts from zero at each frame.

Top module: `symbol_mapper`

## Requirements
- R1: While reset is held, symValid, symFirst, symLast and symSync are 0, and symI and symQ are 0.
- R2: With modeSel = 0 (binary phase), each accepted bit is one symbol: bit 0 gives symI = +3 and bit 1 gives symI = -3, with symQ = 0.
- R3: With modeSel = 1 (quadrature phase), two bits form a symbol, the first received bit being the MSB. The Gray phase map is 00 to π/4, 01 to 3π/4, 11 to -3π/4 and 10 to -π/4. The output point is (round(3cos θ), round(3sin θ)), that is (±2, ±2).
- R4: With modeSel = 2 (differential), the dibit (first bit MSB) selects m: 00 gives 0, 01 gives 1, 11 gives 2 and 10 gives 3. The phase advances by π/4 + m·π/2 from the previous symbol. The output is (round(3cos θ), round(3sin θ)), giving (±3,0), (0,±3) or (±2,±2).
- R5: In the differential mode the phase before the first symbol of every frame is 0, so that symbol's phase is π/4 + m·π/2.
- R6: With modeSel = 3 (16-point), four bits form a symbol: the first two set symI and the last two set symQ. On each axis the first bit is the MSB, and 00 gives -3, 01 gives -1, 11 gives +1 and 10 gives +3.
- R7: symValid is high for exactly one cycle, in the cycle after the clock edge that accepts the last bit of a group. When symValid is low, symI, symQ and the flags are 0. Bits are accepted only when bitValid is high.
- R8: A frame is 136 symbols. symFirst is high with the first symbol of a frame and symLast with the 136th, and the next symbol starts a new frame.
- R9: symSync is high for the symbols that carry the first 32 bits of a frame: 32 symbols in mode 0, 16 in modes 1 and 2, and 8 in mode 3.
- R10: modeSel is sampled on the first accepted bit of each frame. Changes made at any other time take effect only from the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bitValid | input | 1 | Qualifies bitIn for this cycle |
| bitIn | input | 1 | Serial data bit |
| modeSel | input | 2 | Requested modulation: 0 binary, 1 quadrature, 2 differential, 3 16-point |
| symValid | output | 1 | One-cycle symbol strobe |
| symI | output | 4 | Signed in-phase amplitude code |
| symQ | output | 4 | Signed quadrature amplitude code |
| symFirst | output | 1 | Symbol is the first of its frame |
| symLast | output | 1 | Symbol is the last of its frame |
| symSync | output | 1 | Symbol carries preamble bits |

## Verification
The assertions assume that bitIn is a defined level in every cycle where bitValid is high. They also assume that the stream starts on a frame boundary after reset, so the counters and the latched mode describe real frame positions. modeSel may change at any time. The stimulus therefore drives random bits with random gaps in bitValid and sends whole frames in each modulation. It also moves modeSel in the middle of a differential frame to show that the change is deferred. A behavioural model in the bench, built from queues and trigonometric rounding, predicts every output on every cycle.

// File: rtl/symmap_pkg.sv
package symmap_pkg;

  typedef enum logic [1:0] {
    MODE_BPSK  = 2'd0,
    MODE_QPSK  = 2'd1,
    MODE_DQPSK = 2'd2,
    MODE_QAM16 = 2'd3
  } mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic  shiftEn;    // a bit is taken this cycle
    logic  symDone;    // this bit closes a symbol
    logic  frameHead;  // closing symbol is frame symbol 0
    logic  frameTail;  // closing symbol is the last of the frame
    logic  syncSym;    // closing symbol carries preamble bits
    mode_e mode;       // modulation in force for this bit
  } ctrl_strobe_t;

  function automatic logic [1:0] lastBitOf(input mode_e m);
    case (m)
      MODE_BPSK:  return 2'd0;
      MODE_QAM16: return 2'd3;
      default:    return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/symmap_ctrl.sv
module symmap_ctrl
  import symmap_pkg::*;
#(
  parameter int FRAME_SYMS = 136,
  parameter int SYNC_BITS  = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bitValid,
  input  logic [1:0]   modeSel,
  output ctrl_strobe_t strobe
);

  localparam int SYM_W = $clog2(FRAME_SYMS + 1);
  localparam logic [SYM_W-1:0] LAST_SYM   = SYM_W'(FRAME_SYMS - 1);
  localparam logic [SYM_W-1:0] SYNC_ONE   = SYM_W'(SYNC_BITS);
  localparam logic [SYM_W-1:0] SYNC_TWO   = SYM_W'(SYNC_BITS / 2);
  localparam logic [SYM_W-1:0] SYNC_FOUR  = SYM_W'(SYNC_BITS / 4);

  logic [1:0]       bitCnt;
  logic [SYM_W-1:0] symCnt;
  mode_e            activeMode;

  logic             atBoundary;
  mode_e            curMode;
  logic [1:0]       lastBit;
  logic [SYM_W-1:0] syncLimit;
  logic             groupEnd;

  assign atBoundary = (bitCnt == 2'd0) && (symCnt == '0);
  assign curMode    = atBoundary ? mode_e'(modeSel) : activeMode;
  assign lastBit    = lastBitOf(curMode);
  assign groupEnd   = bitValid && (bitCnt == lastBit);

  always_comb begin
    case (curMode)
      MODE_BPSK:  syncLimit = SYNC_ONE;
      MODE_QAM16: syncLimit = SYNC_FOUR;
      default:    syncLimit = SYNC_TWO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bitCnt     <= 2'd0;
      symCnt     <= '0;
      activeMode <= MODE_BPSK;
    end else if (bitValid) begin
      if (atBoundary) activeMode <= curMode;
      if (groupEnd) begin
        bitCnt <= 2'd0;
        symCnt <= (symCnt == LAST_SYM) ? '0 : symCnt + 1'b1;
      end else begin
        bitCnt <= bitCnt + 2'd1;
      end
    end
  end

  always_comb begin
    strobe.shiftEn   = bitValid;
    strobe.symDone   = groupEnd;
    strobe.frameHead = (symCnt == '0);
    strobe.frameTail = (symCnt == LAST_SYM);
    strobe.syncSym   = (symCnt < syncLimit);
    strobe.mode      = curMode;
  end

  AST_MODE_HELD_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !atBoundary |=> activeMode == $past(activeMode)); // R10

  AST_SYMCNT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    symCnt <= LAST_SYM); // R8

  AST_FRAME_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.symDone && strobe.frameTail) |=> (symCnt == '0)); // R8

  AST_BITCNT_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    !atBoundary |-> bitCnt <= lastBitOf(activeMode)); // R7

endmodule

// File: rtl/symmap_datapath.sv
module symmap_datapath
  import symmap_pkg::*;
#(
  parameter int AMP_W     = 4,
  parameter int AMP_FULL  = 3,
  parameter int AMP_DIAG  = 2,
  parameter int QAM_OUTER = 3,
  parameter int QAM_INNER = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bitIn,
  input  ctrl_strobe_t            strobe,
  output logic                    symValid,
  output logic signed [AMP_W-1:0] symI,
  output logic signed [AMP_W-1:0] symQ,
  output logic                    symFirst,
  output logic                    symLast,
  output logic                    symSync
);

  localparam logic signed [AMP_W-1:0] A_FULL  = AMP_W'(AMP_FULL);
  localparam logic signed [AMP_W-1:0] A_DIAG  = AMP_W'(AMP_DIAG);
  localparam logic signed [AMP_W-1:0] Q_OUTER = AMP_W'(QAM_OUTER);
  localparam logic signed [AMP_W-1:0] Q_INNER = AMP_W'(QAM_INNER);

  // cosine of k*pi/4 at the ring amplitude
  function automatic logic signed [AMP_W-1:0] ringCos(input logic [2:0] k);
    case (k)
      3'd0:    return A_FULL;
      3'd1:    return A_DIAG;
      3'd2:    return '0;
      3'd3:    return -A_DIAG;
      3'd4:    return -A_FULL;
      3'd5:    return -A_DIAG;
      3'd6:    return '0;
      default: return A_DIAG;
    endcase
  endfunction

  // level index 0..3 after Gray decode
  function automatic logic signed [AMP_W-1:0] qamLevel(input logic [1:0] g);
    case (g)
      2'd0:    return -Q_OUTER;
      2'd1:    return -Q_INNER;
      2'd2:    return Q_INNER;
      default: return Q_OUTER;
    endcase
  endfunction

  function automatic logic [1:0] grayIdx(input logic [1:0] b);
    return {b[1], b[1] ^ b[0]};
  endfunction

  logic [2:0] shiftReg;
  logic [3:0] nibble;
  logic [1:0] stepM;
  logic [2:0] phaseIdx;
  logic [2:0] phaseNext;
  logic [2:0] tabIdx;
  logic signed [AMP_W-1:0] pointI, pointQ;
  mode_e outMode;

  assign nibble    = {shiftReg, bitIn};
  assign stepM     = grayIdx(nibble[1:0]);
  assign phaseNext = (strobe.frameHead ? 3'd0 : phaseIdx) + {stepM, 1'b0} + 3'd1;

  always_comb begin
    case (strobe.mode)
      MODE_BPSK:  tabIdx = {bitIn, 2'b00};
      MODE_QPSK:  tabIdx = {stepM, 1'b1};
      MODE_DQPSK: tabIdx = phaseNext;
      default:    tabIdx = 3'd0;
    endcase
  end

  always_comb begin
    if (strobe.mode == MODE_QAM16) begin
      pointI = qamLevel(grayIdx(nibble[3:2]));
      pointQ = qamLevel(grayIdx(nibble[1:0]));
    end else begin
      pointI = ringCos(tabIdx);
      pointQ = ringCos(tabIdx - 3'd2);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shiftReg <= 3'd0;
      phaseIdx <= 3'd0;
    end else begin
      if (strobe.shiftEn) shiftReg <= nibble[2:0];
      if (strobe.symDone && strobe.mode == MODE_DQPSK) phaseIdx <= phaseNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !strobe.symDone) begin
      symValid <= 1'b0;
      symI     <= '0;
      symQ     <= '0;
      symFirst <= 1'b0;
      symLast  <= 1'b0;
      symSync  <= 1'b0;
      outMode  <= MODE_BPSK;
    end else begin
      symValid <= 1'b1;
      symI     <= pointI;
      symQ     <= pointQ;
      symFirst <= strobe.frameHead;
      symLast  <= strobe.frameTail;
      symSync  <= strobe.syncSym;
      outMode  <= strobe.mode;
    end
  end

  AST_BPSK_NO_QUAD: assert property (@(posedge clk) disable iff (!rst_n)
    (symValid && outMode == MODE_BPSK) |-> symQ == '0); // R2

  AST_DIFF_ODD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.symDone && strobe.mode == MODE_DQPSK && !strobe.frameHead)
      |=> (((phaseIdx - $past(phaseIdx)) & 3'd1) == 3'd1)); // R4

  AST_DIFF_HEAD_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.symDone && strobe.mode == MODE_DQPSK && strobe.frameHead)
      |=> phaseIdx[0]); // R5

  AST_IDLE_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !symValid |-> (symI == '0 && symQ == '0 && !symFirst && !symLast && !symSync)); // R7

endmodule

// File: rtl/symbol_mapper.sv
module symbol_mapper
  import symmap_pkg::*;
#(
  parameter int FRAME_SYMS = 136,
  parameter int SYNC_BITS  = 32,
  parameter int AMP_W      = 4,
  parameter int AMP_FULL   = 3,
  parameter int AMP_DIAG   = 2,
  parameter int QAM_OUTER  = 3,
  parameter int QAM_INNER  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bitValid,
  input  logic             bitIn,
  input  logic [1:0]       modeSel,
  output logic             symValid,
  output logic [AMP_W-1:0] symI,
  output logic [AMP_W-1:0] symQ,
  output logic             symFirst,
  output logic             symLast,
  output logic             symSync
);

  ctrl_strobe_t strobe;

  symmap_ctrl #(
    .FRAME_SYMS(FRAME_SYMS),
    .SYNC_BITS (SYNC_BITS)
  ) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .bitValid(bitValid),
    .modeSel (modeSel),
    .strobe  (strobe)
  );

  symmap_datapath #(
    .AMP_W    (AMP_W),
    .AMP_FULL (AMP_FULL),
    .AMP_DIAG (AMP_DIAG),
    .QAM_OUTER(QAM_OUTER),
    .QAM_INNER(QAM_INNER)
  ) dp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .bitIn   (bitIn),
    .strobe  (strobe),
    .symValid(symValid),
    .symI    (symI),
    .symQ    (symQ),
    .symFirst(symFirst),
    .symLast (symLast),
    .symSync (symSync)
  );

endmodule

// File: tb/symbol_mapper_tb.sv
module symbol_mapper_tb_top;

  localparam int  CLK_PERIOD = 10;
  localparam int  FRAME      = 136;
  localparam int  SYNC       = 32;
  localparam real PI         = 3.14159265358979;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bitValid = 1'b0;
  logic       bitIn = 1'b0;
  logic [1:0] modeSel = 2'd0;
  logic       symValid, symFirst, symLast, symSync;
  logic [3:0] symI, symQ;

  symbol_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .bitValid(bitValid), .bitIn(bitIn),
    .modeSel(modeSel), .symValid(symValid), .symI(symI), .symQ(symQ),
    .symFirst(symFirst), .symLast(symLast), .symSync(symSync)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int errors  = 0;

  // reference model state
  int mSymCnt  = 0;
  int mMode    = 0;
  int phaseDeg = 0;
  bit pend[$];
  bit eV, eF, eL, eS;
  int eI, eQ;
  string eTag;

  function automatic int ringAmp(int deg, bit useSin);
    real r = deg * PI / 180.0;
    real v = useSin ? $sin(r) : $cos(r);
    return $rtoi($floor(3.0 * v + 0.5));
  endfunction

  function automatic int qamLvl(bit a, bit b);
    case ({a, b})
      2'b00:   return -3;
      2'b01:   return -1;
      2'b11:   return 1;
      default: return 3;
    endcase
  endfunction

  function automatic int grayDeg(bit a, bit b);
    case ({a, b})
      2'b00:   return 45;
      2'b01:   return 135;
      2'b11:   return 225;
      default: return 315;
    endcase
  endfunction

  task automatic modelStep();
    int need;
    eV = 0; eF = 0; eL = 0; eS = 0; eI = 0; eQ = 0; eTag = "R7";
    if (!bitValid) return;
    if (pend.size() == 0 && mSymCnt == 0) mMode = int'(modeSel);
    pend.push_back(bitIn);
    need = (mMode == 0) ? 1 : (mMode == 3) ? 4 : 2;
    if (pend.size() < need) return;
    eV = 1;
    case (mMode)
      0: begin eI = pend[0] ? -3 : 3; eQ = 0; eTag = "R2"; end
      1: begin
        eI = ringAmp(grayDeg(pend[0], pend[1]), 0);
        eQ = ringAmp(grayDeg(pend[0], pend[1]), 1);
        eTag = "R3";
      end
      2: begin
        if (mSymCnt == 0) phaseDeg = 0;
        phaseDeg = (phaseDeg + grayDeg(pend[0], pend[1])) % 360;
        eI = ringAmp(phaseDeg, 0);
        eQ = ringAmp(phaseDeg, 1);
        eTag = (mSymCnt == 0) ? "R5" : "R4";
      end
      default: begin
        eI = qamLvl(pend[0], pend[1]);
        eQ = qamLvl(pend[2], pend[3]);
        eTag = "R6";
      end
    endcase
    if (int'(modeSel) != mMode) eTag = "R10";
    eF = (mSymCnt == 0);
    eL = (mSymCnt == FRAME - 1);
    eS = (mSymCnt * need < SYNC);
    mSymCnt = (mSymCnt + 1) % FRAME;
    pend.delete();
  endtask

  task automatic compareAll();
    int aI = int'($signed(symI));
    int aQ = int'($signed(symQ));
    bit bad = 0;
    vectors++;
    if (symValid !== eV) begin
      bad = 1; $display("FAIL R7 symValid actual %0b expected %0b", symValid, eV);
    end
    if (aI != eI || aQ != eQ) begin
      bad = 1;
      $display("FAIL %s point actual (%0d,%0d) expected (%0d,%0d)", eTag, aI, aQ, eI, eQ);
    end
    if (symFirst !== eF || symLast !== eL) begin
      bad = 1;
      $display("FAIL R8 first/last actual %0b%0b expected %0b%0b", symFirst, symLast, eF, eL);
    end
    if (symSync !== eS) begin
      bad = 1; $display("FAIL R9 symSync actual %0b expected %0b", symSync, eS);
    end
    if (bad) errors++;
  endtask

  task automatic driveBits(int nBits, int modeReq, int gapPct);
    int sent = 0;
    while (sent < nBits) begin
      modeSel  = 2'(modeReq);
      bitValid = (($urandom % 100) >= gapPct);
      bitIn    = 1'($urandom);
      if (bitValid) sent++;
      @(posedge clk);
      modelStep();
      @(negedge clk);
      compareAll();
    end
    bitValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    vectors++;
    if (symValid !== 1'b0 || symI !== 4'd0 || symQ !== 4'd0 ||
        symFirst !== 1'b0 || symLast !== 1'b0 || symSync !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset outputs actual v%0b i%0d q%0d expected all zero",
               symValid, symI, symQ);
    end
    rst_n = 1'b1;

    driveBits(2 * FRAME, 0, 0);        // R2, R8, R9
    driveBits(2 * FRAME, 1, 30);       // R3
    driveBits(4 * FRAME, 2, 20);       // R4, R5 across two frames
    driveBits(4 * FRAME, 3, 0);        // R6
    driveBits(FRAME, 2, 10);           // half a differential frame
    driveBits(FRAME, 3, 10);           // R10: request ignored until boundary
    driveBits(4 * FRAME, 3, 25);       // new frame in 16-point
    driveBits(40, 1, 50);              // partial quadrature frame
    driveBits(FRAME * 2 - 40, 0, 0);   // R10: stays quadrature to the end
    driveBits(FRAME, 0, 0);            // R2 after boundary
    repeat (5) begin
      @(posedge clk); modelStep(); @(negedge clk); compareAll();  // R7 idle
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL R7 watchdog actual running expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule